// File: doc/BRIEF.md
# Non-blocking Load Buffer with Tag Wakeup

This block tracks loads in flight in a speculative core. Each issued load comes with an address, a destination tag and an uncacheable flag. In the same cycle the external cache gives its hit or miss answer. A cacheable hit completes at once and wakes up dependent instructions. It takes no buffer slot, so hits keep completing while earlier misses are still pending. A cacheable miss takes a slot and sends a request to memory. Several misses can be outstanding together, and their refills may come back in any order.

Loads to uncacheable space have side effects, so the block never sends them out speculatively. Such a load sits in its slot until the core marks its destination tag as non-speculative. When refill data returns, the destination tag and the data are broadcast on a single wakeup port. A cache hit in the same cycle wins that port, and the refill waits one cycle in a skid register. A flush drops every slot that is still speculative. Slots that already sent a request stay reserved until their refill arrives, and that refill is then discarded without a wakeup.

Top module: `load_buffer_nb`

## Requirements
- R1: After reset, issue_ready=1, refill_ready=1, mem_req_valid=0 and wake_valid=0.
- R2: An accepted issue with issue_uncached=0 and cache_hit=1 gives wake_valid=1 in the next cycle, with wake_tag=issue_tag and wake_data=cache_data. It takes no slot, and it completes even while misses are outstanding.
- R3: An accepted issue with issue_uncached=0 and cache_hit=0 takes the lowest-index free slot. From the next cycle the request is shown on mem_req_valid/mem_req_idx/mem_req_addr with mem_req_uncached=0, until a cycle with mem_req_ready=1 accepts it.
- R4: Up to NUM_ENTRIES loads can be held at once, including several with accepted requests. While all slots are occupied, issue_ready=0 and an issue (hit or miss) has no effect.
- R5: An accepted refill whose refill_idx names a slot waiting for data gives wake_valid=1 in the next cycle, with that slot's tag and refill_data, if no hit is being woken. The slot is free from that next cycle. Refills may return in any order.
- R6: If a hit and a refill are accepted in the same cycle, the hit is woken in the next cycle and the refill in the cycle after. refill_ready=0 while the refill is held.
- R7: For an uncacheable issue, cache_hit is ignored and no wakeup results. Its slot sends no request until a nonspec_valid cycle whose nonspec_tag equals its tag, arriving after the issue cycle. Its request then carries mem_req_uncached=1.
- R8: Among slots ready to send, the lowest index is presented first whatever the issue order, so a younger cacheable miss goes ahead of an older uncacheable load that is still held.
- R9: In a cycle with flush=1, issue_ready=0. Slots without a non-speculative mark that have not sent their request are freed. Marked slots are kept. A refill for a flushed slot that had already sent its request gives no wakeup.
- R10: A flushed slot whose request was already accepted stays occupied until its refill arrives, and is free in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | A load is offered |
| issue_addr | input | ADDR_W | Load address |
| issue_tag | input | TAG_W | Destination tag |
| issue_uncached | input | 1 | Load targets uncacheable space |
| issue_ready | output | 1 | A load can be accepted this cycle |
| cache_hit | input | 1 | Cache lookup answer for the offered load |
| cache_data | input | DATA_W | Data on a hit |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_idx | output | IDX_W | Slot index of the request |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_uncached | output | 1 | Request is uncacheable |
| mem_req_ready | input | 1 | Memory accepts the request |
| refill_valid | input | 1 | Refill data returning |
| refill_idx | input | IDX_W | Slot index the refill belongs to |
| refill_data | input | DATA_W | Refill data |
| refill_ready | output | 1 | Refill can be accepted |
| nonspec_valid | input | 1 | A tag is now non-speculative |
| nonspec_tag | input | TAG_W | Tag that became non-speculative |
| flush | input | 1 | Discard speculative loads |
| wake_valid | output | 1 | Wakeup broadcast |
| wake_tag | output | TAG_W | Tag being woken |
| wake_data | output | DATA_W | Load result |

## Verification
If a slot is in the wrong state, the ports show it within a cycle or two. It may send a request that should be held, skip its request, give a wakeup for a flushed load, or leave issue_ready in the wrong level because the slot count is off. A wrong priority or skid state shows as a lost or reordered wakeup one cycle after a hit meets a refill. The bench therefore checks request indices, wakeup tags and the ready levels cycle by cycle after each stimulus.

// File: rtl/lb_pkg.sv
package lb_pkg;
   typedef enum logic [2:0] {
      E_FREE = 3'd0,   // slot unused
      E_HOLD = 3'd1,   // uncacheable, waiting for non-speculative mark
      E_REQ  = 3'd2,   // ready to send memory request
      E_WAIT = 3'd3,   // request sent, waiting for refill
      E_DEAD = 3'd4    // flushed after send, waiting to drop refill
   } ent_state_t;
endpackage

// File: rtl/lb_pick.sv
module lb_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/lb_entry.sv
module lb_entry
   import lb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [ADDR_W-1:0] alloc_addr,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic              alloc_unc,
   input  logic              ns_valid,
   input  logic [TAG_W-1:0]  ns_tag,
   input  logic              flush,
   input  logic              grant,
   input  logic              refill_hit,
   output ent_state_t        state,
   output logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  tag,
   output logic              unc,
   output logic              nonspec
);
   ent_state_t nxt;
   logic       ns_hit;

   assign ns_hit = ns_valid && (ns_tag == tag) && (state != E_FREE);

   always_comb begin
      nxt = state;
      unique case (state)
         E_FREE:  if (alloc)      nxt = alloc_unc ? E_HOLD : E_REQ;
         E_HOLD:  if (ns_hit)     nxt = E_REQ;
         E_REQ:   if (grant)      nxt = E_WAIT;
         E_WAIT:  if (refill_hit) nxt = E_FREE;
         E_DEAD:  if (refill_hit) nxt = E_FREE;
         default:                 nxt = E_FREE;
      endcase
      if (flush && !nonspec && state != E_FREE) begin
         if (nxt == E_WAIT)                        nxt = E_DEAD;
         else if (nxt == E_HOLD || nxt == E_REQ)   nxt = E_FREE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= E_FREE;
         nonspec <= 1'b0;
         addr    <= '0;
         tag     <= '0;
         unc     <= 1'b0;
      end else begin
         state <= nxt;
         if (state == E_FREE && alloc) begin
            addr    <= alloc_addr;
            tag     <= alloc_tag;
            unc     <= alloc_unc;
            nonspec <= 1'b0;
         end else if (ns_hit) begin
            nonspec <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/lb_wake.sv
module lb_wake #(
   parameter int TAG_W  = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_v,
   input  logic [TAG_W-1:0]  hit_tag,
   input  logic [DATA_W-1:0] hit_data,
   input  logic              rf_v,
   input  logic [TAG_W-1:0]  rf_tag,
   input  logic [DATA_W-1:0] rf_data,
   output logic              skid_busy,
   output logic              wk_v,
   output logic [TAG_W-1:0]  wk_tag,
   output logic [DATA_W-1:0] wk_data
);
   logic              skid_v;
   logic [TAG_W-1:0]  skid_tag;
   logic [DATA_W-1:0] skid_data;

   assign skid_busy = skid_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wk_v      <= 1'b0;
         wk_tag    <= '0;
         wk_data   <= '0;
         skid_v    <= 1'b0;
         skid_tag  <= '0;
         skid_data <= '0;
      end else if (hit_v) begin
         wk_v    <= 1'b1;
         wk_tag  <= hit_tag;
         wk_data <= hit_data;
         if (rf_v) begin
            skid_v    <= 1'b1;
            skid_tag  <= rf_tag;
            skid_data <= rf_data;
         end
      end else if (skid_v) begin
         wk_v    <= 1'b1;
         wk_tag  <= skid_tag;
         wk_data <= skid_data;
         skid_v  <= 1'b0;
      end else if (rf_v) begin
         wk_v    <= 1'b1;
         wk_tag  <= rf_tag;
         wk_data <= rf_data;
      end else begin
         wk_v <= 1'b0;
      end
   end
endmodule

// File: rtl/load_buffer_nb.sv
module load_buffer_nb
   import lb_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int ADDR_W      = 32,
   parameter int TAG_W       = 6,
   parameter int DATA_W      = 32,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic [TAG_W-1:0]  issue_tag,
   input  logic              issue_uncached,
   output logic              issue_ready,
   input  logic              cache_hit,
   input  logic [DATA_W-1:0] cache_data,
   output logic              mem_req_valid,
   output logic [IDX_W-1:0]  mem_req_idx,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic              mem_req_uncached,
   input  logic              mem_req_ready,
   input  logic              refill_valid,
   input  logic [IDX_W-1:0]  refill_idx,
   input  logic [DATA_W-1:0] refill_data,
   output logic              refill_ready,
   input  logic              nonspec_valid,
   input  logic [TAG_W-1:0]  nonspec_tag,
   input  logic              flush,
   output logic              wake_valid,
   output logic [TAG_W-1:0]  wake_tag,
   output logic [DATA_W-1:0] wake_data
);
   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("load_buffer_nb: NUM_ENTRIES must be at least 2");
   end
   if (TAG_W < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("load_buffer_nb: widths must be positive");
   end

   ent_state_t        e_state [NUM_ENTRIES];
   logic [ADDR_W-1:0] e_addr  [NUM_ENTRIES];
   logic [TAG_W-1:0]  e_tag   [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] e_unc, ns_vec, busy, want_req;
   logic [NUM_ENTRIES-1:0] alloc_vec, grant_vec, refill_vec;

   logic             free_found;
   logic [IDX_W-1:0] free_idx;
   logic             issue_fire, hit_fire, alloc_fire, refill_fire, rf_wake;
   logic             skid_busy;
   ent_state_t       rf_state;
   logic [TAG_W-1:0] rf_tag;

   assign issue_ready  = free_found && !flush;
   assign issue_fire   = issue_valid && issue_ready;
   assign hit_fire     = issue_fire && !issue_uncached && cache_hit;
   assign alloc_fire   = issue_fire && !hit_fire;
   assign refill_ready = !skid_busy;
   assign refill_fire  = refill_valid && refill_ready;
   assign rf_wake      = refill_fire && (rf_state == E_WAIT);

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
      assign busy[g]       = (e_state[g] != E_FREE);
      assign want_req[g]   = (e_state[g] == E_REQ);
      assign alloc_vec[g]  = alloc_fire && (free_idx == IDX_W'(g));
      assign grant_vec[g]  = mem_req_valid && mem_req_ready && (mem_req_idx == IDX_W'(g));
      assign refill_vec[g] = refill_fire && (refill_idx == IDX_W'(g));

      lb_entry #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc      (alloc_vec[g]),
         .alloc_addr (issue_addr),
         .alloc_tag  (issue_tag),
         .alloc_unc  (issue_uncached),
         .ns_valid   (nonspec_valid),
         .ns_tag     (nonspec_tag),
         .flush      (flush),
         .grant      (grant_vec[g]),
         .refill_hit (refill_vec[g]),
         .state      (e_state[g]),
         .addr       (e_addr[g]),
         .tag        (e_tag[g]),
         .unc        (e_unc[g]),
         .nonspec    (ns_vec[g])
      );
   end

   lb_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_free (
      .vec   (~busy),
      .found (free_found),
      .idx   (free_idx)
   );

   lb_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_req (
      .vec   (want_req),
      .found (mem_req_valid),
      .idx   (mem_req_idx)
   );

   always_comb begin
      mem_req_addr     = '0;
      mem_req_uncached = 1'b0;
      rf_state         = E_FREE;
      rf_tag           = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (mem_req_idx == IDX_W'(i)) begin
            mem_req_addr     = e_addr[i];
            mem_req_uncached = e_unc[i];
         end
         if (refill_idx == IDX_W'(i)) begin
            rf_state = e_state[i];
            rf_tag   = e_tag[i];
         end
      end
   end

   lb_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_v     (hit_fire),
      .hit_tag   (issue_tag),
      .hit_data  (cache_data),
      .rf_v      (rf_wake),
      .rf_tag    (rf_tag),
      .rf_data   (refill_data),
      .skid_busy (skid_busy),
      .wk_v      (wake_valid),
      .wk_tag    (wake_tag),
      .wk_data   (wake_data)
   );
endmodule

// File: rtl/lb_chk.sv
module lb_chk #(
   parameter int NUM_ENTRIES = 4,
   parameter int TAG_W       = 6,
   parameter int IDX_W       = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   issue_valid,
   input logic                   issue_ready,
   input logic                   issue_uncached,
   input logic [TAG_W-1:0]       issue_tag,
   input logic                   cache_hit,
   input logic                   mem_req_valid,
   input logic [IDX_W-1:0]       mem_req_idx,
   input logic                   mem_req_uncached,
   input logic                   refill_ready,
   input logic                   flush,
   input logic                   wake_valid,
   input logic [TAG_W-1:0]       wake_tag,
   input logic [NUM_ENTRIES-1:0] busy_vec,
   input logic [NUM_ENTRIES-1:0] ns_vec
);
   // R2: an accepted cacheable hit is broadcast next cycle
   p_hit_wakes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready && !issue_uncached && cache_hit)
      |=> (wake_valid && wake_tag == $past(issue_tag)));

   // R4: no acceptance while every slot is held
   p_full_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy_vec) |-> !issue_ready);

   // R6: a held refill is always followed by a broadcast
   p_skid_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !refill_ready |=> wake_valid);

   // R7: uncacheable requests only leave from marked slots
   p_unc_nonspec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_uncached) |-> ns_vec[mem_req_idx]);

   // R9: after a flush only marked slots may request
   p_flush_spec_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!mem_req_valid || ns_vec[mem_req_idx]));

   // R9: no acceptance in a flush cycle
   p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !issue_ready);
endmodule

bind load_buffer_nb lb_chk #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .TAG_W       (TAG_W),
   .IDX_W       (IDX_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .issue_valid      (issue_valid),
   .issue_ready      (issue_ready),
   .issue_uncached   (issue_uncached),
   .issue_tag        (issue_tag),
   .cache_hit        (cache_hit),
   .mem_req_valid    (mem_req_valid),
   .mem_req_idx      (mem_req_idx),
   .mem_req_uncached (mem_req_uncached),
   .refill_ready     (refill_ready),
   .flush            (flush),
   .wake_valid       (wake_valid),
   .wake_tag         (wake_tag),
   .busy_vec         (busy),
   .ns_vec           (ns_vec)
);

// File: tb/tb_load_buffer_nb.sv
module tb_load_buffer_nb;
   localparam int CLK_P  = 10;
   localparam int N      = 4;
   localparam int AW     = 32;
   localparam int TW     = 6;
   localparam int DW     = 32;
   localparam int IW     = 2;
   localparam int NVEC   = 6;
   localparam logic [TW-1:0] VT [NVEC] = '{6'd1, 6'd7, 6'd63, 6'd0, 6'd42, 6'd5};
   localparam logic [DW-1:0] VD [NVEC] = '{32'h1111_0001, 32'hFFFF_FFFF, 32'h0,
                                           32'hA5A5_5A5A, 32'h0000_002A, 32'h8000_0000};

   logic clk = 1'b0, rst_n = 1'b0;
   logic issue_valid = 0, issue_uncached = 0, cache_hit = 0;
   logic [AW-1:0] issue_addr = '0;
   logic [TW-1:0] issue_tag = '0, nonspec_tag = '0;
   logic [DW-1:0] cache_data = '0, refill_data = '0;
   logic mem_req_ready = 0, refill_valid = 0, nonspec_valid = 0, flush = 0;
   logic [IW-1:0] refill_idx = '0;
   logic issue_ready, mem_req_valid, mem_req_uncached, refill_ready, wake_valid;
   logic [IW-1:0] mem_req_idx;
   logic [AW-1:0] mem_req_addr;
   logic [TW-1:0] wake_tag;
   logic [DW-1:0] wake_data;

   int total = 0, bad = 0;
   bit finished = 0;

   always #(CLK_P/2) clk = ~clk;

   load_buffer_nb #(.NUM_ENTRIES(N), .ADDR_W(AW), .TAG_W(TW), .DATA_W(DW)) dut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic quiet();
      issue_valid = 0; issue_uncached = 0; cache_hit = 0;
      refill_valid = 0; nonspec_valid = 0; flush = 0;
   endtask

   task automatic issue(input logic [TW-1:0] t, input logic [AW-1:0] a,
                        input logic unc, input logic hit, input logic [DW-1:0] d);
      issue_valid = 1; issue_tag = t; issue_addr = a;
      issue_uncached = unc; cache_hit = hit; cache_data = d;
   endtask

   task automatic refill(input logic [IW-1:0] i, input logic [DW-1:0] d);
      refill_valid = 1; refill_idx = i; refill_data = d;
   endtask

   task automatic wake_is(input string req, input logic [TW-1:0] t, input logic [DW-1:0] d);
      chk({req, " wake_valid"}, 64'(wake_valid), 64'd1);
      chk({req, " wake_tag"}, 64'(wake_tag), 64'(t));
      chk({req, " wake_data"}, 64'(wake_data), 64'(d));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      // R1 reset state
      chk("R1 issue_ready", 64'(issue_ready), 64'd1);
      chk("R1 refill_ready", 64'(refill_ready), 64'd1);
      chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
      chk("R1 wake_valid", 64'(wake_valid), 64'd0);

      // R2 table of back-to-back hits
      for (int k = 0; k < NVEC; k++) begin
         issue(VT[k], 32'h1000 + 32'(k), 0, 1, VD[k]);
         cyc();
         wake_is("R2 table", VT[k], VD[k]);
      end
      quiet();
      cyc();
      chk("R2 idle wake", 64'(wake_valid), 64'd0);

      // R3 miss, R4 miss-under-miss, R2 hit-under-miss, R5 out-of-order refill
      issue(6'd10, 32'h100, 0, 0, 32'h0);
      cyc(); quiet();
      chk("R3 req_valid", 64'(mem_req_valid), 64'd1);
      chk("R3 req_idx", 64'(mem_req_idx), 64'd0);
      chk("R3 req_addr", 64'(mem_req_addr), 64'h100);
      chk("R3 req_unc", 64'(mem_req_uncached), 64'd0);
      chk("R3 miss no wake", 64'(wake_valid), 64'd0);
      mem_req_ready = 1;
      issue(6'd11, 32'h200, 0, 0, 32'h0);
      cyc(); quiet();
      chk("R4 second req_idx", 64'(mem_req_idx), 64'd1);
      chk("R4 second req_addr", 64'(mem_req_addr), 64'h200);
      issue(6'd12, 32'h300, 0, 1, 32'hC0DE);
      cyc(); quiet(); mem_req_ready = 0;
      wake_is("R2 hit-under-miss", 6'd12, 32'hC0DE);
      chk("R4 both sent", 64'(mem_req_valid), 64'd0);
      refill(2'd1, 32'hBB);
      cyc(); quiet();
      wake_is("R5 refill idx1", 6'd11, 32'hBB);
      refill(2'd0, 32'hAA);
      cyc(); quiet();
      wake_is("R5 refill idx0", 6'd10, 32'hAA);
      cyc();
      chk("R5 idle wake", 64'(wake_valid), 64'd0);

      // R6 hit and refill in the same cycle
      mem_req_ready = 1;
      issue(6'd20, 32'h300, 0, 0, 32'h0);
      cyc(); quiet();
      cyc(); mem_req_ready = 0;
      issue(6'd21, 32'h340, 0, 1, 32'h21);
      refill(2'd0, 32'h20);
      #1 chk("R6 refill_ready before", 64'(refill_ready), 64'd1);
      cyc(); quiet();
      wake_is("R6 hit first", 6'd21, 32'h21);
      chk("R6 refill_ready held", 64'(refill_ready), 64'd0);
      cyc();
      wake_is("R6 refill second", 6'd20, 32'h20);
      chk("R6 refill_ready back", 64'(refill_ready), 64'd1);
      cyc();

      // R4 fill every slot, then R3 lowest-first sending
      for (int k = 0; k < N; k++) begin
         issue(6'(30 + k), 32'h400 + 32'(k * 4), 0, 0, 32'h0);
         cyc();
      end
      quiet();
      chk("R4 full stall", 64'(issue_ready), 64'd0);
      issue(6'd35, 32'h500, 0, 1, 32'h35);
      cyc(); quiet();
      chk("R4 issue ignored when full", 64'(wake_valid), 64'd0);
      mem_req_ready = 1;
      for (int k = 0; k < N; k++) begin
         chk("R3 send order", 64'(mem_req_idx), 64'(k));
         chk("R3 send addr", 64'(mem_req_addr), 64'(32'h400 + 32'(k * 4)));
         cyc();
      end
      mem_req_ready = 0;
      chk("R4 all outstanding", 64'(mem_req_valid), 64'd0);
      refill(2'd2, 32'h32);
      cyc(); quiet();
      wake_is("R5 refill slot2", 6'd32, 32'h32);
      chk("R5 slot freed", 64'(issue_ready), 64'd1);
      refill(2'd0, 32'h30); cyc();
      wake_is("R5 refill slot0", 6'd30, 32'h30);
      refill(2'd1, 32'h31); cyc();
      wake_is("R5 refill slot1", 6'd31, 32'h31);
      refill(2'd3, 32'h33); cyc(); quiet();
      wake_is("R5 refill slot3", 6'd33, 32'h33);
      cyc();

      // R7 uncacheable held, R8 younger miss goes first
      issue(6'd40, 32'hF000, 1, 1, 32'hDEAD);
      cyc(); quiet();
      chk("R7 hit ignored", 64'(wake_valid), 64'd0);
      chk("R7 held", 64'(mem_req_valid), 64'd0);
      issue(6'd41, 32'h500, 0, 0, 32'h0);
      cyc(); quiet();
      chk("R8 younger first valid", 64'(mem_req_valid), 64'd1);
      chk("R8 younger first idx", 64'(mem_req_idx), 64'd1);
      chk("R8 younger cached", 64'(mem_req_uncached), 64'd0);
      mem_req_ready = 1;
      cyc(); mem_req_ready = 0;
      chk("R7 still held", 64'(mem_req_valid), 64'd0);
      nonspec_valid = 1; nonspec_tag = 6'd41;
      cyc(); quiet();
      chk("R7 other tag no release", 64'(mem_req_valid), 64'd0);
      nonspec_valid = 1; nonspec_tag = 6'd40;
      cyc(); quiet();
      chk("R7 released", 64'(mem_req_valid), 64'd1);
      chk("R7 idx", 64'(mem_req_idx), 64'd0);
      chk("R7 uncached flag", 64'(mem_req_uncached), 64'd1);
      chk("R7 addr", 64'(mem_req_addr), 64'hF000);
      mem_req_ready = 1;
      cyc(); mem_req_ready = 0;
      refill(2'd0, 32'h40); cyc();
      wake_is("R7 uncached done", 6'd40, 32'h40);
      refill(2'd1, 32'h41); cyc(); quiet();
      wake_is("R5 cached done", 6'd41, 32'h41);
      cyc();

      // R9 / R10 flush
      issue(6'd50, 32'h600, 0, 0, 32'h0);
      cyc(); quiet(); mem_req_ready = 1;
      cyc(); mem_req_ready = 0;
      issue(6'd51, 32'h700, 0, 0, 32'h0);
      cyc();
      issue(6'd52, 32'hF100, 1, 0, 32'h0);
      cyc(); quiet();
      nonspec_valid = 1; nonspec_tag = 6'd52;
      cyc(); quiet();
      chk("R8 lowest before flush", 64'(mem_req_idx), 64'd1);
      flush = 1;
      #1 chk("R9 flush blocks issue", 64'(issue_ready), 64'd0);
      cyc(); quiet();
      chk("R9 marked kept valid", 64'(mem_req_valid), 64'd1);
      chk("R9 marked kept idx", 64'(mem_req_idx), 64'd2);
      chk("R9 marked kept unc", 64'(mem_req_uncached), 64'd1);
      issue(6'd53, 32'h800, 0, 0, 32'h0);
      cyc();
      issue(6'd54, 32'h900, 0, 0, 32'h0);
      cyc(); quiet();
      chk("R10 drained slot held", 64'(issue_ready), 64'd0);
      chk("R9 freed slot reused", 64'(mem_req_idx), 64'd1);
      refill(2'd0, 32'hDEAD);
      cyc(); quiet();
      chk("R9 dropped refill no wake", 64'(wake_valid), 64'd0);
      chk("R10 drained slot freed", 64'(issue_ready), 64'd1);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule